// File: doc/BRIEF.md
# Keyed-restart watchdog timer

A memory-mapped countdown watchdog with a 32-bit register window. Software loads a reload value, turns the timer on, and must then keep writing a fixed 16-bit key to a restart register before the count runs out. The count runs down either once per clock or once per microsecond. The microsecond tick comes from an internal prescaler that divides the peripheral clock.

When the count runs out, the block stops. It can send a one-cycle reset request, set a sticky interrupt, or both, as the control register selects. An external hold input, raised while the memory controller is being reset, vetoes the expiry. In that case no reset and no interrupt are issued, and the control register is cleared. The reset-mode and external-signal control fields are driven out as plain outputs so that downstream reset-shaping logic can use them.

Top module: `kwdt_top`

## Requirements
- R1: After reset the count and the reload value are both 0x014FB180, the control register is 0, the timer is stopped, `irq` is 0 and `rst_req` is 0.
- R2: The word register map is as follows. Offset 0x00 is the count; it is read-only and writes to it have no effect. Offset 0x04 is the reload value, read/write. Offset 0x08 is the restart register, which reads as 0. Offset 0x0C is control, where bits 6:0 are stored and bits 31:7 read as 0. Any offset of 0x10 or above reads 0, and writes to it change nothing.
- R3: An access has an effect only when `bus_be` is 4'hF and `bus_addr[1:0]` is 0. Any other read returns 0, and any other write is ignored.
- R4: A write to 0x08 whose bits 15:0 equal 0x4755 does four things: it loads the count from the reload value, clears the prescaler, clears `irq`, and resumes counting if enable (control bit 0) is 1. Bits 31:16 of that write are not checked. A write to 0x08 with any other value changes nothing.
- R5: A control write that takes bit 0 from 0 to 1 loads the count from the reload value and starts counting. A control write that takes bit 0 from 1 to 0 stops the count and holds its value. Any other control write only updates the stored bits.
- R6: With control bit 4 clear, the count drops by one on every clock edge while the timer runs. After a load of N (N ≥ 1), it reads N−k after k further edges.
- R7: With control bit 4 set, the count drops once every CLK_HZ/TICK_HZ clocks (24 by default). The first drop comes exactly that many clocks after a load.
- R8: A tick taken while the count is 1 or less sets the count to 0 and stops the timer. If control bit 1 is set, `rst_req` is then high for exactly one cycle.
- R9: On expiry with control bit 2 set, `irq` goes high and stays high. Only a keyed restart (R4) or reset clears it.
- R10: If `mem_rst_hold` is high when expiry occurs, `rst_req` stays low, `irq` is not set, the control register becomes 0 and the timer stops.
- R11: `rst_mode` equals control bits 6:5 and `ext_en` equals control bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address inside the window |
| bus_be | input | 4 | Byte enables; only 4'hF is accepted |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read strobe |
| mem_rst_hold | input | 1 | Memory-controller reset in progress; vetoes expiry |
| rst_req | output | 1 | One-cycle reset request on expiry |
| irq | output | 1 | Sticky expiry interrupt |
| rst_mode | output | 2 | Reset-mode field of control |
| ext_en | output | 1 | External-signal enable bit of control |

## Verification
The countdown is run under both tick sources. A short reload in per-clock mode checks the exact cycle of expiry. A three-step reload in microsecond mode shows whether the prescaler phase is reset on each load. Restart writes cover the exact key with junk in the upper half, a key that is off by one, and the exact key with partial byte enables; this separates key matching from access validation. Control writes with and without an enable edge show that only edges reload or stop the count. Expiry is run with the memory-reset hold both high and low, which shows the veto and the clearing of control.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;

    localparam int unsigned   DATA_W     = 32;
    localparam int unsigned   CTRL_W     = 7;
    localparam logic [15:0]   RESTART_KEY = 16'h4755;
    localparam logic [31:0]   COUNT_INIT = 32'h014F_B180;

    // Word index inside the first 16 bytes of the window.
    typedef enum logic [1:0] {
        WORD_COUNT   = 2'd0,
        WORD_RELOAD  = 2'd1,
        WORD_RESTART = 2'd2,
        WORD_CTRL    = 2'd3
    } reg_word_e;

    // Control layout, MSB first: mode[6:5], fast_tick[4], ext_en[3],
    // irq_en[2], sys_rst_en[1], en[0].
    typedef struct packed {
        logic [1:0] mode;
        logic       fast_tick;
        logic       ext_en;
        logic       irq_en;
        logic       sys_rst_en;
        logic       en;
    } ctrl_t;

    // Commands from the register decode to the counter.
    typedef struct packed {
        logic load;       // reload count from reload value
        logic stop;       // halt counting
        logic key;        // valid restart key seen
        logic run_after;  // running state that follows a load
    } cmd_t;

    function automatic ctrl_t ctrl_from_word(input logic [DATA_W-1:0] w);
        return ctrl_t'(w[CTRL_W-1:0]);
    endfunction

    function automatic logic key_match(input logic [DATA_W-1:0] w);
        return w[15:0] == RESTART_KEY;
    endfunction

endpackage

// File: rtl/kwdt_regs.sv
module kwdt_regs
    import kwdt_pkg::*;
#(
    parameter int unsigned ADDR_W      = 8,
    parameter logic [31:0] RELOAD_INIT = COUNT_INIT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [3:0]        bus_be,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] cur_count,
    input  logic              ctrl_clear,
    output ctrl_t             ctrl_q,
    output logic [DATA_W-1:0] reload_q,
    output cmd_t              cmd
);

    logic      in_map;
    logic      acc_ok;
    logic      wr_hit;
    logic      rd_hit;
    reg_word_e sel;
    logic      wr_reload;
    logic      wr_restart;
    logic      wr_ctrl;
    ctrl_t     new_ctrl;

    always_comb begin
        in_map     = (bus_addr[ADDR_W-1:4] == '0);
        acc_ok     = bus_en && (bus_be == 4'hF) && (bus_addr[1:0] == 2'b00) && in_map;
        wr_hit     = acc_ok && bus_we;
        rd_hit     = acc_ok && !bus_we;
        sel        = reg_word_e'(bus_addr[3:2]);
        wr_reload  = wr_hit && (sel == WORD_RELOAD);
        wr_restart = wr_hit && (sel == WORD_RESTART);
        wr_ctrl    = wr_hit && (sel == WORD_CTRL);
        new_ctrl   = ctrl_from_word(bus_wdata);
    end

    always_comb begin
        cmd.key       = wr_restart && key_match(bus_wdata);
        cmd.load      = cmd.key || (wr_ctrl && new_ctrl.en && !ctrl_q.en);
        cmd.stop      = wr_ctrl && !new_ctrl.en && ctrl_q.en;
        cmd.run_after = wr_ctrl ? 1'b1 : ctrl_q.en;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            reload_q <= RELOAD_INIT;
        end else begin
            if (wr_reload) begin
                reload_q <= bus_wdata;
            end
            if (wr_ctrl) begin
                ctrl_q <= new_ctrl;
            end else if (ctrl_clear) begin
                ctrl_q <= '0;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (rd_hit) begin
            unique case (sel)
                WORD_COUNT:   bus_rdata = cur_count;
                WORD_RELOAD:  bus_rdata = reload_q;
                WORD_CTRL:    bus_rdata = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
                default:      bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/kwdt_tick.sv
module kwdt_tick #(
    parameter int unsigned DIV = 24
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic tick
);

    localparam int unsigned     PW   = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0]   LAST = PW'(DIV - 1);

    logic [PW-1:0] cnt;

    assign tick = (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/kwdt_count.sv
module kwdt_count
    import kwdt_pkg::*;
#(
    parameter logic [31:0] COUNT_RESET = COUNT_INIT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  cmd_t              cmd,
    input  logic [DATA_W-1:0] reload_q,
    input  logic              irq_en,
    input  logic              sys_rst_en,
    input  logic              mem_rst_hold,
    output logic [DATA_W-1:0] cur_count,
    output logic              running,
    output logic              ctrl_clear,
    output logic              rst_req,
    output logic              irq
);

    logic at_end;
    logic expire;
    logic fire;

    always_comb begin
        at_end     = (cur_count <= DATA_W'(1));
        expire     = running && tick && at_end && !cmd.load && !cmd.stop;
        fire       = expire && !mem_rst_hold;
        ctrl_clear = expire && mem_rst_hold;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_count <= COUNT_RESET;
            running   <= 1'b0;
            rst_req   <= 1'b0;
            irq       <= 1'b0;
        end else begin
            rst_req <= fire && sys_rst_en;

            if (cmd.load) begin
                cur_count <= reload_q;
                running   <= cmd.run_after;
            end else if (cmd.stop) begin
                running <= 1'b0;
            end else if (running && tick) begin
                if (at_end) begin
                    cur_count <= '0;
                    running   <= 1'b0;
                end else begin
                    cur_count <= cur_count - 1'b1;
                end
            end

            if (cmd.key) begin
                irq <= 1'b0;
            end else if (fire && irq_en) begin
                irq <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
    import kwdt_pkg::*;
#(
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned CLK_HZ      = 24_000_000,
    parameter int unsigned TICK_HZ     = 1_000_000,
    parameter logic [31:0] RESET_COUNT = COUNT_INIT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [3:0]        bus_be,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              mem_rst_hold,
    output logic              rst_req,
    output logic              irq,
    output logic [1:0]        rst_mode,
    output logic              ext_en
);

    localparam int unsigned PRE_DIV = CLK_HZ / TICK_HZ;

    ctrl_t             ctrl_q;
    cmd_t              cmd;
    logic [DATA_W-1:0] reload_q;
    logic [DATA_W-1:0] cur_count;
    logic              ctrl_clear;
    logic              running;
    logic              pre_tick;
    logic              tick;
    logic              key_hit;
    logic              load_req;
    logic              stop_req;

    kwdt_regs #(
        .ADDR_W      (ADDR_W),
        .RELOAD_INIT (RESET_COUNT)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .bus_en     (bus_en),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_be     (bus_be),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .cur_count  (cur_count),
        .ctrl_clear (ctrl_clear),
        .ctrl_q     (ctrl_q),
        .reload_q   (reload_q),
        .cmd        (cmd)
    );

    generate
        if (PRE_DIV > 1) begin : g_pre
            kwdt_tick #(.DIV(PRE_DIV)) u_tick (
                .clk  (clk),
                .rst  (rst),
                .clr  (cmd.load),
                .tick (pre_tick)
            );
        end else begin : g_nopre
            assign pre_tick = 1'b1;
        end
    endgenerate

    assign tick = ctrl_q.fast_tick ? pre_tick : 1'b1;

    kwdt_count #(
        .COUNT_RESET (RESET_COUNT)
    ) u_count (
        .clk          (clk),
        .rst          (rst),
        .tick         (tick),
        .cmd          (cmd),
        .reload_q     (reload_q),
        .irq_en       (ctrl_q.irq_en),
        .sys_rst_en   (ctrl_q.sys_rst_en),
        .mem_rst_hold (mem_rst_hold),
        .cur_count    (cur_count),
        .running      (running),
        .ctrl_clear   (ctrl_clear),
        .rst_req      (rst_req),
        .irq          (irq)
    );

    assign key_hit  = cmd.key;
    assign load_req = cmd.load;
    assign stop_req = cmd.stop;
    assign rst_mode = ctrl_q.mode;
    assign ext_en   = ctrl_q.ext_en;

endmodule

// File: rtl/kwdt_chk.sv
module kwdt_chk (
    input logic        clk,
    input logic        rst,
    input logic        rst_req,
    input logic        irq,
    input logic        mem_rst_hold,
    input logic [6:0]  ctrl_bits,
    input logic        key_hit,
    input logic        load_req,
    input logic        stop_req,
    input logic        running,
    input logic [31:0] cur_count
);

    // R8
    rst_req_single_chk: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> !rst_req);

    // R8
    rst_req_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> (cur_count == 32'd0));

    // R10
    hold_veto_chk: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> !$past(mem_rst_hold));

    // R9
    irq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (irq && !key_hit) |=> irq);

    // R9
    irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(ctrl_bits[2]));

    // R5
    stop_halts_chk: assert property (@(posedge clk) disable iff (rst)
        stop_req |=> !running);

    // R6
    no_count_up_chk: assert property (@(posedge clk) disable iff (rst)
        !load_req |=> (cur_count <= $past(cur_count)));

endmodule

bind kwdt_top kwdt_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .rst_req      (rst_req),
    .irq          (irq),
    .mem_rst_hold (mem_rst_hold),
    .ctrl_bits    (ctrl_q),
    .key_hit      (key_hit),
    .load_req     (load_req),
    .stop_req     (stop_req),
    .running      (running),
    .cur_count    (cur_count)
);

// File: tb/tb_kwdt_top.sv
module tb_kwdt_top;

    localparam logic [7:0] A_COUNT   = 8'h00;
    localparam logic [7:0] A_RELOAD  = 8'h04;
    localparam logic [7:0] A_RESTART = 8'h08;
    localparam logic [7:0] A_CTRL    = 8'h0C;
    localparam logic [31:0] C_EN   = 32'h01;
    localparam logic [31:0] C_SR   = 32'h02;
    localparam logic [31:0] C_IE   = 32'h04;
    localparam logic [31:0] C_FAST = 32'h10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [3:0]  bus_be = 4'hF;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        mem_rst_hold = 1'b0;
    logic        rst_req;
    logic        irq;
    logic [1:0]  rst_mode;
    logic        ext_en;

    int tests = 0;
    int fails = 0;
    int pulses = 0;

    kwdt_top dut (
        .clk          (clk),
        .rst          (rst),
        .bus_en       (bus_en),
        .bus_we       (bus_we),
        .bus_addr     (bus_addr),
        .bus_be       (bus_be),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .mem_rst_hold (mem_rst_hold),
        .rst_req      (rst_req),
        .irq          (irq),
        .rst_mode     (rst_mode),
        .ext_en       (ext_en)
    );

    always #4 clk = ~clk;

    always @(negedge clk) if (rst_req) pulses++;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0; bus_be = 4'hF;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d, input logic [3:0] be = 4'hF);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a; bus_be = be;
        #1 d = bus_rdata;
        #1 bus_en = 1'b0; bus_be = 4'hF;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(A_COUNT, v);   chk("R1 count", v, 32'h014FB180);
        rd(A_RELOAD, v);  chk("R1 reload", v, 32'h014FB180);
        rd(A_CTRL, v);    chk("R1 ctrl", v, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 rst_req", {31'b0, rst_req}, 32'h0);
        rd(A_RESTART, v); chk("R2 restart reads zero", v, 32'h0);
        repeat (3) @(negedge clk);
        rd(A_COUNT, v);   chk("R1 stopped after reset", v, 32'h014FB180);
    endtask

    task automatic t_map();
        logic [31:0] v;
        wr(A_COUNT, 32'h5);             rd(A_COUNT, v);  chk("R2 count read-only", v, 32'h014FB180);
        wr(A_RELOAD, 32'h1234);         rd(A_RELOAD, v); chk("R2 reload rw", v, 32'h1234);
        wr(A_RELOAD, 32'h99, 4'h3);     rd(A_RELOAD, v); chk("R3 partial write ignored", v, 32'h1234);
        wr(8'h05, 32'h77);              rd(A_RELOAD, v); chk("R3 unaligned write ignored", v, 32'h1234);
        rd(A_RELOAD, v, 4'h1);          chk("R3 partial read zero", v, 32'h0);
        rd(8'h10, v);                   chk("R2 out-of-map read zero", v, 32'h0);
        wr(8'h44, 32'h55);              rd(A_RELOAD, v); chk("R2 out-of-map write ignored", v, 32'h1234);
        wr(A_CTRL, 32'hFFFF_FF68);      rd(A_CTRL, v);   chk("R2 ctrl stored bits", v, 32'h68);
        chk("R11 rst_mode", {30'b0, rst_mode}, 32'h3);
        chk("R11 ext_en", {31'b0, ext_en}, 32'h1);
        wr(A_CTRL, 32'h0);
        chk("R11 rst_mode cleared", {30'b0, rst_mode}, 32'h0);
    endtask

    task automatic t_slow();
        logic [31:0] v;
        int p0;
        wr(A_RELOAD, 32'd20);
        wr(A_CTRL, C_EN | C_SR);
        p0 = pulses;
        rd(A_COUNT, v); chk("R5 enable rise loads", v, 32'd20);
        repeat (19) @(negedge clk);
        rd(A_COUNT, v); chk("R6 count after 19 edges", v, 32'd1);
        chk("R8 no early rst_req", {31'b0, rst_req}, 32'h0);
        @(negedge clk);
        chk("R8 rst_req at expiry", {31'b0, rst_req}, 32'h1);
        rd(A_COUNT, v); chk("R8 count zero", v, 32'd0);
        @(negedge clk);
        chk("R8 rst_req one cycle", {31'b0, rst_req}, 32'h0);
        repeat (5) @(negedge clk);
        rd(A_COUNT, v); chk("R8 stopped at zero", v, 32'd0);
        chk("R8 single pulse", pulses - p0, 32'd1);
        chk("R9 no irq when disabled", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_ctrl_edges();
        logic [31:0] v;
        wr(A_RELOAD, 32'd100);
        wr(A_CTRL, C_EN | C_SR);
        rd(A_COUNT, v); chk("R5 no reload without edge", v, 32'd0);
        wr(A_CTRL, 32'h0);
        wr(A_CTRL, C_EN);
        rd(A_COUNT, v); chk("R5 rise reloads", v, 32'd100);
        repeat (10) @(negedge clk);
        rd(A_COUNT, v); chk("R6 ten edges", v, 32'd90);
        wr(A_CTRL, C_EN | C_IE);
        rd(A_COUNT, v); chk("R5 plain write keeps counting", v, 32'd88);
        wr(A_CTRL, 32'h0);
        rd(A_COUNT, v); chk("R5 fall stops", v, 32'd87);
        repeat (5) @(negedge clk);
        rd(A_COUNT, v); chk("R5 count held", v, 32'd87);
    endtask

    task automatic t_key();
        logic [31:0] v;
        wr(A_RELOAD, 32'd50);
        wr(A_CTRL, C_EN);
        repeat (10) @(negedge clk);
        rd(A_COUNT, v); chk("R6 count 40", v, 32'd40);
        wr(A_RESTART, 32'h0000_4756);
        rd(A_COUNT, v); chk("R4 wrong key ignored", v, 32'd38);
        wr(A_RESTART, 32'hFFFF_4755);
        rd(A_COUNT, v); chk("R4 key reloads", v, 32'd50);
        wr(A_RESTART, 32'h0000_4755, 4'h3);
        rd(A_COUNT, v); chk("R3 partial key ignored", v, 32'd48);
        wr(A_CTRL, 32'h0);
    endtask

    task automatic t_fast();
        logic [31:0] v;
        int p0;
        wr(A_RELOAD, 32'd3);
        wr(A_CTRL, C_EN | C_IE | C_FAST);
        p0 = pulses;
        rd(A_COUNT, v); chk("R7 loaded", v, 32'd3);
        repeat (23) @(negedge clk);
        rd(A_COUNT, v); chk("R7 no drop before period", v, 32'd3);
        @(negedge clk);
        rd(A_COUNT, v); chk("R7 first drop", v, 32'd2);
        repeat (47) @(negedge clk);
        rd(A_COUNT, v); chk("R7 count 1", v, 32'd1);
        chk("R9 irq low before expiry", {31'b0, irq}, 32'h0);
        @(negedge clk);
        chk("R9 irq set", {31'b0, irq}, 32'h1);
        rd(A_COUNT, v); chk("R8 count zero fast", v, 32'd0);
        repeat (30) @(negedge clk);
        chk("R9 irq sticky", {31'b0, irq}, 32'h1);
        chk("R8 no rst_req when off", pulses - p0, 32'd0);
        wr(A_RESTART, 32'h0000_4755);
        chk("R4 key clears irq", {31'b0, irq}, 32'h0);
        rd(A_COUNT, v); chk("R4 key reloads fast", v, 32'd3);
        repeat (23) @(negedge clk);
        rd(A_COUNT, v); chk("R7 prescaler cleared", v, 32'd3);
        @(negedge clk);
        rd(A_COUNT, v); chk("R7 exact period after key", v, 32'd2);
        wr(A_CTRL, 32'h0);
    endtask

    task automatic t_hold();
        logic [31:0] v;
        int p0;
        mem_rst_hold = 1'b1;
        wr(A_RELOAD, 32'd5);
        wr(A_CTRL, C_EN | C_SR | C_IE);
        p0 = pulses;
        repeat (8) @(negedge clk);
        rd(A_CTRL, v);  chk("R10 ctrl cleared", v, 32'h0);
        rd(A_COUNT, v); chk("R10 count stopped", v, 32'd0);
        chk("R10 no irq", {31'b0, irq}, 32'h0);
        chk("R10 no rst_req", pulses - p0, 32'd0);
        mem_rst_hold = 1'b0;
        wr(A_CTRL, C_EN | C_SR);
        repeat (5) @(negedge clk);
        chk("R8 rst_req once hold released", {31'b0, rst_req}, 32'h1);
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_map();
        t_slow();
        t_ctrl_edges();
        t_key();
        t_fast();
        t_hold();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule